// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces, one per clock, the column addresses of a single SDRAM read or write burst. A controller pulses `startPulse` with the first column, the burst length code and the burst type held in its mode register. From the next cycle on, the generator drives `colOut` with one column per cycle and holds `colValid` high for the whole burst. It raises `colLast` on the final beat.

For burst lengths 2, 4 and 8 the upper column bits fix an aligned block and the low bits count within it. Sequential order adds the beat count to the starting offset. Interleaved order XORs the two. In both cases the address wraps inside the block. A full-page burst steps through the whole row, wrapping from the top column to zero, and runs until it is stopped. A stop request ends a burst of any length. A new start during a burst restarts the generator at once, as a fresh column command interrupting an older one would.

Top module: `colBurstGen`

## Requirements
- R1: Out of reset `colValid` and `colLast` are low and `colOut` is zero.
- R2: When `startPulse` is sampled high on a clock edge with a supported length code, `colOut` equals the sampled `startCol` and `colValid` is high in the following cycle.
- R3: Length codes are `lenCode`=000 (1 beat), 001 (2), 010 (4), 011 (8), 111 (full page). A fixed-length burst gives exactly that many beats on consecutive cycles. `colLast` is high on the final beat only, and `colValid` is low in the cycle after the final beat unless a new start was sampled.
- R4: With `burstType`=0 (sequential), beat i of a 2, 4 or 8 beat burst has the upper column bits of the start and low bits equal to (start offset + i) modulo the length.
- R5: With `burstType`=1 (interleaved), beat i of a 2, 4 or 8 beat burst has the upper column bits of the start and low bits equal to start offset XOR i.
- R6: A 1-beat burst outputs only the start column, with `colLast` high on that beat, for either value of `burstType`.
- R7: A full-page burst steps up by one column per cycle, wraps from the highest column (1023 at the default width) to 0, ignores `burstType`, and never raises `colLast`.
- R8: When `stopReq` is sampled high during a burst with no start in the same cycle, `colValid` is low in the next cycle. When `startPulse` and `stopReq` are sampled together, the start wins.
- R9: A start with a supported code during a burst abandons the old burst. The new burst's first column appears in the next cycle.
- R10: A start with a reserved length code (100, 101, 110) is ignored. An idle generator stays idle, and a running burst continues unchanged.
- R11: `colOut` is zero whenever `colValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a burst at `startCol` |
| stopReq | input | 1 | End the running burst |
| startCol | input | COL_W | First column of the burst |
| lenCode | input | 3 | Burst length code |
| burstType | input | 1 | 0 sequential, 1 interleaved |
| colOut | output | COL_W | Current column address |
| colValid | output | 1 | A burst beat is being output |
| colLast | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The assertions assume that `lenCode` and `burstType` are stable only when sampled together with `startPulse`. Between starts they may change freely, since the design latches them. The assertions also assume that `stopReq` arriving while the generator is idle is harmless. The bench changes inputs only on falling edges. It pulses start for a single cycle, and it drops stop right after the cycle it was meant for. This keeps every sampled combination one that the requirements define. The sweeps cover each fixed length in both orders over many start columns near both ends of the row. The full-page runs cross the top of the row.

// File: rtl/colBurstPkg.sv
package colBurstPkg;

  typedef enum logic [2:0] {
    LEN_ONE  = 3'd0,
    LEN_TWO  = 3'd1,
    LEN_FOUR = 3'd2,
    LEN_EIGHT = 3'd3,
    LEN_ROW  = 3'd4,
    LEN_RSV  = 3'd5
  } lenSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // latch start column and mode
    logic step;    // advance to next beat
    logic active;  // a beat is on the outputs
  } burstStb_t;

  function automatic lenSel_e decodeLen(input logic [2:0] code);
    case (code)
      3'b000:  decodeLen = LEN_ONE;
      3'b001:  decodeLen = LEN_TWO;
      3'b010:  decodeLen = LEN_FOUR;
      3'b011:  decodeLen = LEN_EIGHT;
      3'b111:  decodeLen = LEN_ROW;
      default: decodeLen = LEN_RSV;
    endcase
  endfunction

endpackage

// File: rtl/colBurstCtrl.sv
module colBurstCtrl
  import colBurstPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      stopReq,
  input  logic [2:0] lenCode,
  input  logic      blockEnd,
  output burstStb_t stb,
  output logic      colValid,
  output logic      colLast
);

  logic    activeR;
  lenSel_e sel;
  logic    codeOk;
  logic    loadNow;

  assign sel     = decodeLen(lenCode);
  assign codeOk  = (sel != LEN_RSV);
  assign loadNow = startPulse && codeOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeR <= 1'b0;
    end else if (loadNow) begin
      activeR <= 1'b1;
    end else if (activeR && (blockEnd || stopReq)) begin
      activeR <= 1'b0;
    end
  end

  always_comb begin
    stb.load   = loadNow;
    stb.step   = activeR && !blockEnd && !stopReq && !loadNow;
    stb.active = activeR;
  end

  assign colValid = activeR;
  assign colLast  = activeR && blockEnd;

  // R3
  after_last_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (colLast && !startPulse) |=> !colValid);

  // R8
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && stopReq && !startPulse) |=> !colValid);

  // R10
  reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!colValid && startPulse && lenCode[2] && (lenCode[1:0] != 2'b11)) |=> !colValid);

endmodule

// File: rtl/colBurstPath.sv
module colBurstPath
  import colBurstPkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  burstStb_t        stb,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             burstType,
  output logic [COL_W-1:0] colOut,
  output logic             blockEnd
);

  localparam logic [COL_W-1:0] ONE_COL = COL_W'(1);

  logic [COL_W-1:0] startR;
  logic [COL_W-1:0] cntR;
  logic [COL_W-1:0] maskR;
  logic             intlR;
  logic             rowR;

  lenSel_e          sel;
  logic [COL_W-1:0] maskNew;
  logic [COL_W-1:0] offSeq;
  logic [COL_W-1:0] offIntl;
  logic [COL_W-1:0] offSel;
  logic [COL_W-1:0] colNow;

  assign sel = decodeLen(lenCode);

  always_comb begin
    case (sel)
      LEN_TWO:   maskNew = COL_W'(1);
      LEN_FOUR:  maskNew = COL_W'(3);
      LEN_EIGHT: maskNew = COL_W'(7);
      LEN_ROW:   maskNew = '1;
      default:   maskNew = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startR <= '0;
      cntR   <= '0;
      maskR  <= '0;
      intlR  <= 1'b0;
      rowR   <= 1'b0;
    end else if (stb.load) begin
      startR <= startCol;
      cntR   <= '0;
      maskR  <= maskNew;
      intlR  <= burstType && (sel != LEN_ROW);
      rowR   <= (sel == LEN_ROW);
    end else if (stb.step) begin
      cntR   <= cntR + ONE_COL;
    end
  end

  assign offSeq  = startR + cntR;
  assign offIntl = startR ^ cntR;
  assign offSel  = intlR ? offIntl : offSeq;
  assign colNow  = (startR & ~maskR) | (offSel & maskR);
  assign colOut  = stb.active ? colNow : '0;
  assign blockEnd = !rowR && (cntR == maskR);

  // R2
  load_echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (colOut == $past(startCol)));

  // R4
  seq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.step && !intlR) |=> ((colOut & maskR) == (($past(colOut) + ONE_COL) & maskR)));

  // R5
  block_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> ((colOut & ~maskR) == ($past(colOut) & ~maskR)));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.active |-> (colOut == '0));

endmodule

// File: rtl/colBurstGen.sv
module colBurstGen
  import colBurstPkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             stopReq,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenCode,
  input  logic             burstType,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             colLast
);

  burstStb_t stb;
  logic      blockEnd;

  colBurstCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .stopReq    (stopReq),
    .lenCode    (lenCode),
    .blockEnd   (blockEnd),
    .stb        (stb),
    .colValid   (colValid),
    .colLast    (colLast)
  );

  colBurstPath #(.COL_W(COL_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .startCol  (startCol),
    .lenCode   (lenCode),
    .burstType (burstType),
    .colOut    (colOut),
    .blockEnd  (blockEnd)
  );

endmodule

// File: tb/colBurstGen_bench.sv
module colBurstGen_bench;

  localparam int COL_W = 10;
  localparam int TOP   = (1 << COL_W) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startPulse = 1'b0;
  logic             stopReq = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0]       lenCode = 3'b000;
  logic             burstType = 1'b0;
  logic [COL_W-1:0] colOut;
  logic             colValid;
  logic             colLast;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  colBurstGen #(.COL_W(COL_W)) u_colBurstGen (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stopReq(stopReq),
    .startCol(startCol), .lenCode(lenCode), .burstType(burstType),
    .colOut(colOut), .colValid(colValid), .colLast(colLast)
  );

  function automatic int expCol(int s, int len, int intl, int i);
    int m;
    int off;
    if (len == 0) return (s + i) & TOP;
    m   = len - 1;
    off = intl != 0 ? (s ^ i) : (s + i);
    return ((s & ~m) | (off & m)) & TOP;
  endfunction

  task automatic chk(string req, int col, int vld, int lst);
    checks++;
    if (colOut !== COL_W'(col) || colValid !== 1'(vld) || colLast !== 1'(lst)) begin
      fails++;
      $display("FAIL %s: col=%0d valid=%0d last=%0d expected col=%0d valid=%0d last=%0d",
               req, colOut, colValid, colLast, col, vld, lst);
    end
  endtask

  // called at a falling edge; returns at the falling edge showing beat 0
  task automatic kick(int col, int code, int typ);
    startCol   = COL_W'(col);
    lenCode    = 3'(code);
    burstType  = 1'(typ);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  function automatic int codeOf(int len);
    case (len)
      1: return 0;
      2: return 1;
      4: return 2;
      8: return 3;
      default: return 7;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lens[4] = '{1, 2, 4, 8};
    repeat (3) @(negedge clk);
    chk("R1", 0, 0, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", 0, 0, 0);

    // R2 R3 R4 R5 R6: sweep fixed lengths, both orders, start columns at both ends
    for (int li = 0; li < 4; li++) begin
      for (int t = 0; t < 2; t++) begin
        for (int k = 0; k < 32; k++) begin
          int s = (k < 16) ? k : (TOP - 31 + k);
          int L = lens[li];
          kick(s, codeOf(L), t);
          for (int i = 0; i < L; i++) begin
            if (L == 1)      chk("R6", expCol(s, L, t, i), 1, 1);
            else if (t == 0) chk("R4", expCol(s, L, t, i), 1, (i == L - 1) ? 1 : 0);
            else             chk("R5", expCol(s, L, t, i), 1, (i == L - 1) ? 1 : 0);
            @(negedge clk);
          end
          chk("R3", 0, 0, 0);
        end
      end
    end

    // R2: start column visible in cycle after start
    kick(5, 3, 1);
    chk("R2", 5, 1, 0);
    @(negedge clk);
    chk("R5", 4, 1, 0);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chk("R8", 0, 0, 0);

    // R7: full page wraps 1023 to 0, type ignored, no last
    for (int t = 0; t < 2; t++) begin
      kick(TOP - 3, 7, t);
      for (int i = 0; i < 40; i++) begin
        chk("R7", expCol(TOP - 3, 0, 0, i), 1, 0);
        if (i == 39) stopReq = 1'b1;
        @(negedge clk);
      end
      stopReq = 1'b0;
      chk("R8", 0, 0, 0);
    end

    // R7: full page running more than a whole row
    kick(100, 7, 0);
    for (int i = 0; i < TOP + 20; i++) begin
      chk("R7", expCol(100, 0, 0, i), 1, 0);
      @(negedge clk);
    end
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chk("R8", 0, 0, 0);

    // R8: start and stop together - start wins
    kick(16, 2, 0);
    chk("R4", 16, 1, 0);
    stopReq = 1'b1;
    kick(40, 1, 1);
    stopReq = 1'b0;
    chk("R8", 40, 1, 0);
    @(negedge clk);
    chk("R8", 41, 1, 1);
    @(negedge clk);
    chk("R3", 0, 0, 0);

    // R9: restart mid-burst
    kick(8, 3, 0);
    chk("R9", 8, 1, 0);
    @(negedge clk);
    chk("R9", 9, 1, 0);
    kick(69, 2, 1);
    for (int i = 0; i < 4; i++) begin
      chk("R9", expCol(69, 4, 1, i), 1, (i == 3) ? 1 : 0);
      @(negedge clk);
    end
    chk("R9", 0, 0, 0);

    // R10: reserved codes from idle
    for (int c = 4; c < 7; c++) begin
      kick(300, c, 0);
      chk("R10", 0, 0, 0);
      @(negedge clk);
      chk("R10", 0, 0, 0);
    end

    // R10: reserved code during a burst leaves it running
    kick(32, 2, 0);
    chk("R10", 32, 1, 0);
    kick(500, 5, 1);
    chk("R10", 33, 1, 0);
    @(negedge clk);
    chk("R10", 34, 1, 0);
    @(negedge clk);
    chk("R10", 35, 1, 1);
    @(negedge clk);
    chk("R11", 0, 0, 0);

    // R8: stop while idle is harmless; stop on 1-beat burst
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chk("R11", 0, 0, 0);
    kick(77, 0, 1);
    chk("R6", 77, 1, 1);
    @(negedge clk);
    chk("R11", 0, 0, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule